// File: doc/BRIEF.md
# Timer-Synchronized Double-Buffered Output Port

This block is a parallel output port whose pins change in step with a timer instead of at the moment software writes them. A write to the data register fills a staging register only. The staging value is copied into the pin-driving output register when the chosen timer event arrives. The pin edges therefore line up with timer ticks, whatever the timing of the software.

Each copy sets a sticky interrupt request. Software answers it by writing the next value into the staging register and then writing the acknowledge register. The value then waits for the next tick. A control register selects the update mode and the event source. In immediate mode a data write reaches the pins directly. In synchronized mode the copy waits for one of four sources: every clock cycle, the reload-timer output, compare match 1 or compare match 2.

Top module: `timed_out_port`

## Requirements
- R1: While reset is asserted and after it is released, the staging register, the pins and `irq` are all zero. The port starts in immediate mode with source 0.
- R2: In synchronized mode, a write with `wr_reg`=0 loads only the staging register. `port_out` holds its value until the selected event is sampled.
- R3: When the selected event is sampled high at a clock edge in synchronized mode, `port_out` takes the staging value at that same edge.
- R4: A write with `wr_reg`=1 sets the control register. `wr_data[0]` set to 1 selects synchronized mode. `wr_data[2:1]` selects the source: 0 every cycle, 1 `evt_reload`, 2 `evt_cmp1`, 3 `evt_cmp2`. Pulses on the sources that are not selected change nothing.
- R5: If a data write and the selected event fall in the same cycle, the pins take the old staging value. The new value waits for the next event.
- R6: Every transfer sets `irq`, and `irq` stays set until it is acknowledged.
- R7: Any write with `wr_reg`=2 clears `irq`. If a transfer happens in the same cycle, `irq` stays set.
- R8: In immediate mode, a data write drives `port_out` at the next edge. Timer events then move no data and raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_reg | input | 2 | Register select: 0 data, 1 control, 2 acknowledge |
| wr_data | input | W | Write data |
| evt_reload | input | 1 | Reload-timer output pulse |
| evt_cmp1 | input | 1 | Compare match 1 pulse |
| evt_cmp2 | input | 1 | Compare match 2 pulse |
| port_out | output | W | Output port lines |
| irq | output | 1 | Sticky transfer interrupt request |

## Verification
The bench targets the following corner cases and the failure each one exposes:
- **Write and event in the same cycle.** A design that forwards the new write would show the new value one tick early.
- **Acknowledge and transfer in the same cycle.** If clear won over set, the interrupt for that transfer would be lost.
- **Pulses on unselected sources.** A broken source mux would let them move the pins.
- **Events in immediate mode.** A design that fails here would copy data or raise `irq` where neither may change.
- **Source 0.** The bench checks that every cycle counts as an event and that the pins trail the staging register by one cycle.

// File: rtl/timed_out_port.sv
module timed_out_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_reg,
  input  logic [W-1:0] wr_data,
  input  logic         evt_reload,
  input  logic         evt_cmp1,
  input  logic         evt_cmp2,
  output logic [W-1:0] port_out,
  output logic         irq
);
  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_ACK  = 2'd2;

  logic [W-1:0] stage;
  logic         sync_mode;
  logic [1:0]   src;
  logic [3:0]   evt_vec;
  logic         fire, wr_data_hit, wr_ctrl_hit, wr_ack_hit;

  assign evt_vec     = {evt_cmp2, evt_cmp1, evt_reload, 1'b1};
  assign fire        = sync_mode & evt_vec[src];
  assign wr_data_hit = wr_en && (wr_reg == REG_DATA);
  assign wr_ctrl_hit = wr_en && (wr_reg == REG_CTRL);
  assign wr_ack_hit  = wr_en && (wr_reg == REG_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage     <= '0;
      port_out  <= '0;
      irq       <= 1'b0;
      sync_mode <= 1'b0;
      src       <= 2'd0;
    end else begin
      if (wr_data_hit) stage <= wr_data;
      if (wr_ctrl_hit) begin
        sync_mode <= wr_data[0];
        src       <= wr_data[2:1];
      end
      if (fire)                          port_out <= stage;
      else if (!sync_mode && wr_data_hit) port_out <= wr_data;
      if (fire)            irq <= 1'b1;
      else if (wr_ack_hit) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/timed_out_port_chk.sv
module timed_out_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_reg,
  input logic [W-1:0] wr_data,
  input logic         sync_mode,
  input logic         fire,
  input logic [W-1:0] stage,
  input logic [W-1:0] port_out,
  input logic         irq
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !fire) |=> $stable(port_out));
  p_transfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (port_out == $past(stage)));
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq);
  p_irq_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_reg == 2'd2 && !fire) |=> !irq);
  p_immediate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && wr_en && wr_reg == 2'd0) |=> (port_out == $past(wr_data)));
  p_no_irq_imm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && !irq) |=> !irq);
endmodule

bind timed_out_port timed_out_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_data(wr_data),
  .sync_mode(sync_mode), .fire(fire), .stage(stage), .port_out(port_out), .irq(irq)
);

// File: tb/sim_timed_out_port.sv
module sim_timed_out_port;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_reg = '0;
  logic [W-1:0] wr_data = '0;
  logic evt_reload = 1'b0, evt_cmp1 = 1'b0, evt_cmp2 = 1'b0;
  logic [W-1:0] port_out;
  logic irq;

  typedef struct { logic [W-1:0] port; logic irq; string req; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [W-1:0] m_stage = '0, m_port = '0;
  logic m_irq = 0, m_sync = 0;
  logic [1:0] m_src = '0;

  always #2.5 clk = ~clk;

  timed_out_port #(.W(W)) u0 (.*);

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (port_out !== e.port || irq !== e.irq) begin
        fails++;
        $display("FAIL %s: port=%h irq=%b expected port=%h irq=%b",
                 e.req, port_out, irq, e.port, e.irq);
      end
    end
  end

  task automatic step(input logic we, input logic [1:0] rg, input logic [W-1:0] d,
                      input logic r, input logic c1, input logic c2, input string req);
    logic [3:0] ev;
    logic f;
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_reg = rg; wr_data = d;
    evt_reload = r; evt_cmp1 = c1; evt_cmp2 = c2;
    ev = {c2, c1, r, 1'b1};
    f = m_sync & ev[m_src];
    if (f) m_port = m_stage;
    else if (!m_sync && we && rg == 2'd0) m_port = d;
    if (f) m_irq = 1'b1;
    else if (we && rg == 2'd2) m_irq = 1'b0;
    if (we && rg == 2'd0) m_stage = d;
    if (we && rg == 2'd1) begin m_sync = d[0]; m_src = d[2:1]; end
    e.port = m_port; e.irq = m_irq; e.req = req;
    sb.push_back(e);
    @(posedge clk);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (port_out !== '0 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R1: port=%h irq=%b expected port=00 irq=0", port_out, irq);
    end
    rst_n = 1'b1;
    step(0, 0, 8'h00, 0, 0, 0, "R1");
    step(1, 0, 8'hA5, 0, 0, 0, "R8");
    step(0, 0, 8'h00, 1, 1, 1, "R8");
    step(1, 1, 8'h03, 0, 0, 0, "R4");
    step(1, 0, 8'h3C, 0, 0, 0, "R2");
    step(0, 0, 8'h00, 0, 0, 0, "R2");
    step(0, 0, 8'h00, 0, 1, 1, "R4");
    step(0, 0, 8'h00, 1, 0, 0, "R3");
    step(0, 0, 8'h00, 0, 0, 0, "R6");
    step(1, 2, 8'h00, 0, 0, 0, "R7");
    step(1, 0, 8'h11, 1, 0, 0, "R5");
    step(0, 0, 8'h00, 0, 0, 0, "R5");
    step(1, 2, 8'h00, 1, 0, 0, "R7");
    step(1, 2, 8'h00, 0, 0, 0, "R7");
    step(1, 1, 8'h07, 0, 0, 0, "R4");
    step(1, 0, 8'h77, 1, 1, 0, "R4");
    step(0, 0, 8'h00, 0, 0, 1, "R3");
    step(1, 2, 8'h00, 0, 0, 0, "R7");
    step(1, 1, 8'h01, 0, 0, 0, "R4");
    step(1, 0, 8'h99, 0, 0, 0, "R4");
    step(0, 0, 8'h00, 0, 0, 0, "R4");
    step(1, 1, 8'h00, 0, 0, 0, "R8");
    step(1, 2, 8'h00, 0, 0, 0, "R7");
    step(1, 0, 8'h5A, 1, 1, 1, "R8");
    step(0, 0, 8'h00, 1, 0, 0, "R8");
    step(1, 3, 8'hFF, 0, 0, 0, "R4");
    step(0, 0, 8'h00, 0, 0, 0, "R4");
    @(negedge clk);
    wr_en = 0; evt_reload = 0; evt_cmp1 = 0; evt_cmp2 = 0;
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule